// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host port that writes 32 bits at a time and a bank of 128-bit control registers. Each host write presents a byte address and one dword. Writes that land in the wide-register part of a page are merged in a single collector. The collector issues one 128-bit commit to the target register only when the rule for that register allows it. Writes that land in the narrow part of a page bypass the collector and leave as single commits. The downstream register file sees a one-cycle commit strobe, together with the register address, the 128-bit value and a flag that marks a narrow commit.

The address space is split into pages of 0x2000 bytes. Within a page, offsets from 0x800 upward hold 128-bit registers and lower offsets hold 32-bit registers. Two wide offsets, 0x830 and 0xA10, are descriptor-pointer registers and follow a relaxed rule in every page. The narrow register at offset 0x420 of page 0 empties the collector as a side effect when it is written.

Top module: `wide_write_collector`

## Requirements
- R1: After reset, commit_valid, commit_addr and commit_data are all zero. The collector is empty after reset, including a reset that arrives partway through a collection.
- R2: An ordinary wide register (page offset at or above 0x800, not a descriptor offset) commits only once all four dword lanes have been written, in any order. Lane n is selected by address bits [3:2] and carries data bits [32n+31:32n]. The commit address is the register base with bits [3:0] zero.
- R3: commit_valid pulses high for one cycle in the clock after the completing host write, and never without a write. commit_addr and commit_data hold their values until the next commit.
- R4: Writing the same lane twice before completion replaces that lane. The repeat does not count toward completion twice.
- R5: An ordinary wide write to a different register than the one being collected discards the old partial contents. Collection restarts with only the new lane valid.
- R6: A write to the top lane (offset +12) of a descriptor register always commits. Lower lanes take collector data only when the collector holds that same register, and are zero otherwise.
- R7: A write to a lower lane of a descriptor register is dropped while the collector holds lanes of another register, and those lanes are kept.
- R8: Descriptor registers are recognised at page × 0x2000 + 0x830 and page × 0x2000 + 0xA10 for every page.
- R9: A write to offset 0x420 in page 0 empties the collector. The same offset in any other page does not.
- R10: A write below page offset 0x800 commits on its own with commit_narrow = 1, the data in bits [31:0], zero above, and the address with bits [1:0] cleared. It leaves the collector untouched.
- R11: The collector is empty after every wide commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | 16 | Host byte address |
| wr_data | input | 32 | Host write dword |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_narrow | output | 1 | Commit is a 32-bit register write |
| commit_addr | output | 16 | Address of the register being committed |
| commit_data | output | 128 | Value committed to the register |

## Verification
The bench targets several corner cases. A lane written twice would finish a register early if repeats were counted. A dropped descriptor low-lane write would wipe the partial contents of another register if it were not discarded cleanly. The bench checks that a descriptor top-lane commit zero-fills every lane the collector does not own, and that a narrow write in the middle of a collection neither completes nor disturbs it. It also checks that the page-0 timer offset clears the collector while its page-1 copy does not, and that a reset in the middle of a collection leaves no stale lanes to complete a later register.

// File: rtl/ww_pkg.sv
package ww_pkg;
   typedef enum logic [1:0] {
      WK_NARROW = 2'd0,
      WK_WIDE   = 2'd1,
      WK_DESC   = 2'd2
   } wkind_e;
endpackage

// File: rtl/ww_addr_decode.sv
module ww_addr_decode
   import ww_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int          PAGE_LOG2    = 13,
   parameter int          LANE_LSB     = 2,
   parameter int          LANE_W       = 2,
   parameter logic [31:0] WIDE_BASE    = 32'h800,
   parameter int          NUM_DESC     = 2,
   parameter logic [31:0] DESC_OFS [NUM_DESC] = '{32'h830, 32'hA10},
   parameter logic [31:0] TIMER_OFS    = 32'h420,
   parameter bit          TIMER_CLEARS = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output wkind_e            kind,
   output logic [LANE_W-1:0] lane,
   output logic [ADDR_W-1:0] blk_addr,
   output logic [ADDR_W-1:0] dw_addr,
   output logic              timer_clear
);
   localparam int BLK_LSB = LANE_LSB + LANE_W;
   localparam logic [ADDR_W-1:0]    BLK_MASK_A = ~((ADDR_W'(1) << BLK_LSB) - ADDR_W'(1));
   localparam logic [ADDR_W-1:0]    DW_MASK_A  = ~((ADDR_W'(1) << LANE_LSB) - ADDR_W'(1));
   localparam logic [PAGE_LOG2-1:0] BLK_MASK_P = ~((PAGE_LOG2'(1) << BLK_LSB) - PAGE_LOG2'(1));
   localparam logic [PAGE_LOG2-1:0] DW_MASK_P  = ~((PAGE_LOG2'(1) << LANE_LSB) - PAGE_LOG2'(1));
   localparam logic [PAGE_LOG2-1:0] WIDE_P     = PAGE_LOG2'(WIDE_BASE);

   logic [PAGE_LOG2-1:0] ofs;
   logic [PAGE_LOG2-1:0] ofs_blk;
   logic [NUM_DESC-1:0]  desc_match;

   assign ofs      = addr[PAGE_LOG2-1:0];
   assign ofs_blk  = ofs & BLK_MASK_P;
   assign lane     = addr[LANE_LSB +: LANE_W];
   assign blk_addr = addr & BLK_MASK_A;
   assign dw_addr  = addr & DW_MASK_A;

   for (genvar k = 0; k < NUM_DESC; k++) begin : g_desc
      assign desc_match[k] = (ofs_blk == PAGE_LOG2'(DESC_OFS[k]));
   end

   always_comb begin
      if (ofs < WIDE_P)     kind = WK_NARROW;
      else if (|desc_match) kind = WK_DESC;
      else                  kind = WK_WIDE;
   end

   if (TIMER_CLEARS) begin : g_timer
      logic page_zero;
      assign page_zero   = (addr[ADDR_W-1:PAGE_LOG2] == '0);
      assign timer_clear = page_zero && ((ofs & DW_MASK_P) == PAGE_LOG2'(TIMER_OFS));
   end else begin : g_no_timer
      logic unused_page;
      assign unused_page = |addr[ADDR_W-1:PAGE_LOG2];
      assign timer_clear = 1'b0;
   end
endmodule

// File: rtl/ww_collector.sv
module ww_collector
   import ww_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DWORD_W = 32,
   parameter int LANES   = 4,
   parameter int LANE_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  wkind_e                   kind,
   input  logic [LANE_W-1:0]        lane,
   input  logic [ADDR_W-1:0]        blk_addr,
   input  logic                     timer_clear,
   input  logic [DWORD_W-1:0]       wr_data,
   output logic                     fire,
   output logic [LANES*DWORD_W-1:0] fire_data
);
   logic [ADDR_W-1:0]  tgt_q, tgt_d;
   logic [LANES-1:0]   mask_q, mask_d;
   logic [LANES-1:0]   lane_oh;
   logic [DWORD_W-1:0] slot_q [LANES];
   logic               slot_we;
   logic               hit;
   logic               top;

   assign hit     = (|mask_q) && (tgt_q == blk_addr);
   assign lane_oh = LANES'(1) << lane;
   assign top     = (lane == LANE_W'(LANES - 1));

   always_comb begin
      mask_d  = mask_q;
      tgt_d   = tgt_q;
      slot_we = 1'b0;
      fire    = 1'b0;
      if (wr_en) begin
         unique case (kind)
            WK_NARROW: begin
               if (timer_clear) begin
                  mask_d = '0;
                  tgt_d  = '0;
               end
            end
            WK_DESC: begin
               if (top) begin
                  fire   = 1'b1;
                  mask_d = '0;
                  tgt_d  = '0;
               end else if (!((|mask_q) && !hit)) begin
                  slot_we = 1'b1;
                  mask_d  = mask_q | lane_oh;
                  tgt_d   = blk_addr;
               end
            end
            WK_WIDE: begin
               slot_we = 1'b1;
               mask_d  = (hit ? mask_q : '0) | lane_oh;
               tgt_d   = blk_addr;
               if (&mask_d) begin
                  fire   = 1'b1;
                  mask_d = '0;
                  tgt_d  = '0;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         tgt_q  <= '0;
      end else begin
         mask_q <= mask_d;
         tgt_q  <= tgt_d;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)                                 slot_q[i] <= '0;
         else if (slot_we && lane == LANE_W'(i))     slot_q[i] <= wr_data;
      end
      assign fire_data[i*DWORD_W +: DWORD_W] =
         (lane == LANE_W'(i)) ? wr_data :
         ((hit && mask_q[i]) ? slot_q[i] : '0);
   end
endmodule

// File: rtl/ww_commit_stage.sv
module ww_commit_stage #(
   parameter int ADDR_W  = 16,
   parameter int DWORD_W = 32,
   parameter int DATA_W  = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               is_narrow,
   input  logic               coll_fire,
   input  logic [DATA_W-1:0]  coll_data,
   input  logic [ADDR_W-1:0]  blk_addr,
   input  logic [ADDR_W-1:0]  dw_addr,
   input  logic [DWORD_W-1:0] wr_data,
   output logic               commit_valid,
   output logic               commit_narrow,
   output logic [ADDR_W-1:0]  commit_addr,
   output logic [DATA_W-1:0]  commit_data
);
   logic narrow_fire;
   logic any_fire;

   assign narrow_fire = wr_en && is_narrow;
   assign any_fire    = narrow_fire || coll_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         commit_valid  <= 1'b0;
         commit_narrow <= 1'b0;
         commit_addr   <= '0;
         commit_data   <= '0;
      end else begin
         commit_valid <= any_fire;
         if (any_fire) begin
            commit_narrow <= narrow_fire;
            commit_addr   <= narrow_fire ? dw_addr : blk_addr;
            commit_data   <= narrow_fire ? DATA_W'(wr_data) : coll_data;
         end
      end
   end
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
   import ww_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int          DWORD_W      = 32,
   parameter int          LANES        = 4,
   parameter int          PAGE_LOG2    = 13,
   parameter logic [31:0] WIDE_BASE    = 32'h800,
   parameter int          NUM_DESC     = 2,
   parameter logic [31:0] DESC_OFS [NUM_DESC] = '{32'h830, 32'hA10},
   parameter logic [31:0] TIMER_OFS    = 32'h420,
   parameter bit          TIMER_CLEARS = 1'b1,
   localparam int         DATA_W       = LANES * DWORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DWORD_W-1:0] wr_data,
   output logic               commit_valid,
   output logic               commit_narrow,
   output logic [ADDR_W-1:0]  commit_addr,
   output logic [DATA_W-1:0]  commit_data
);
   localparam int LANE_W   = $clog2(LANES);
   localparam int LANE_LSB = $clog2(DWORD_W / 8);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (DWORD_W < 8 || (DWORD_W % 8) != 0 || ((DWORD_W / 8) & (DWORD_W / 8 - 1)) != 0) begin : g_bad_dword
      $error("DWORD_W must be a power-of-two number of bytes");
   end
   if (ADDR_W <= PAGE_LOG2) begin : g_bad_page
      $error("ADDR_W must exceed PAGE_LOG2");
   end
   if (WIDE_BASE >= (32'd1 << PAGE_LOG2)) begin : g_bad_wide
      $error("WIDE_BASE must lie inside a page");
   end
   for (genvar k = 0; k < NUM_DESC; k++) begin : g_chk_desc
      if (DESC_OFS[k] < WIDE_BASE || (DESC_OFS[k] % (LANES * DWORD_W / 8)) != 0) begin : g_bad_desc
         $error("descriptor offset must be an aligned wide offset");
      end
   end

   wkind_e             kind;
   logic [LANE_W-1:0]  lane;
   logic [ADDR_W-1:0]  blk_addr;
   logic [ADDR_W-1:0]  dw_addr;
   logic               timer_clear;
   logic               coll_fire;
   logic [DATA_W-1:0]  coll_data;

   ww_addr_decode #(
      .ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2), .LANE_LSB(LANE_LSB), .LANE_W(LANE_W),
      .WIDE_BASE(WIDE_BASE), .NUM_DESC(NUM_DESC), .DESC_OFS(DESC_OFS),
      .TIMER_OFS(TIMER_OFS), .TIMER_CLEARS(TIMER_CLEARS)
   ) u_decode (
      .addr(wr_addr), .kind(kind), .lane(lane), .blk_addr(blk_addr),
      .dw_addr(dw_addr), .timer_clear(timer_clear)
   );

   ww_collector #(
      .ADDR_W(ADDR_W), .DWORD_W(DWORD_W), .LANES(LANES), .LANE_W(LANE_W)
   ) u_collector (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .kind(kind), .lane(lane),
      .blk_addr(blk_addr), .timer_clear(timer_clear), .wr_data(wr_data),
      .fire(coll_fire), .fire_data(coll_data)
   );

   ww_commit_stage #(
      .ADDR_W(ADDR_W), .DWORD_W(DWORD_W), .DATA_W(DATA_W)
   ) u_commit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .is_narrow(kind == WK_NARROW),
      .coll_fire(coll_fire), .coll_data(coll_data), .blk_addr(blk_addr),
      .dw_addr(dw_addr), .wr_data(wr_data), .commit_valid(commit_valid),
      .commit_narrow(commit_narrow), .commit_addr(commit_addr), .commit_data(commit_data)
   );
endmodule

// File: rtl/ww_collector_chk.sv
module ww_collector_chk #(
   parameter int          ADDR_W    = 16,
   parameter int          DWORD_W   = 32,
   parameter int          LANES     = 4,
   parameter int          PAGE_LOG2 = 13,
   parameter logic [31:0] WIDE_BASE = 32'h800,
   parameter int          NUM_DESC  = 2,
   parameter logic [31:0] DESC_OFS [NUM_DESC] = '{32'h830, 32'hA10},
   parameter int          DATA_W    = LANES * DWORD_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [DWORD_W-1:0] wr_data,
   input logic               commit_valid,
   input logic               commit_narrow,
   input logic [ADDR_W-1:0]  commit_addr,
   input logic [DATA_W-1:0]  commit_data
);
   localparam int BLK_LSB = $clog2(LANES) + $clog2(DWORD_W / 8);
   localparam logic [ADDR_W-1:0]    BLK_MASK = ~((ADDR_W'(1) << BLK_LSB) - ADDR_W'(1));
   localparam logic [PAGE_LOG2-1:0] BLK_MASK_P = ~((PAGE_LOG2'(1) << BLK_LSB) - PAGE_LOG2'(1));
   localparam logic [PAGE_LOG2-1:0] TOP_OFS = PAGE_LOG2'((LANES - 1) * (DWORD_W / 8));

   logic [PAGE_LOG2-1:0] ofs;
   logic in_narrow;
   logic in_desc;
   logic desc_top;

   assign ofs       = wr_addr[PAGE_LOG2-1:0];
   assign in_narrow = (ofs < PAGE_LOG2'(WIDE_BASE));

   always_comb begin
      in_desc = 1'b0;
      for (int k = 0; k < NUM_DESC; k++)
         if ((ofs & BLK_MASK_P) == PAGE_LOG2'(DESC_OFS[k])) in_desc = 1'b1;
   end
   assign desc_top = in_desc && ((ofs & ~BLK_MASK_P & ~PAGE_LOG2'(DWORD_W / 8 - 1)) == TOP_OFS);

   assert_commit_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> $past(wr_en));

   assert_narrow_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_narrow) |=> (commit_valid && commit_narrow &&
                                commit_data[DWORD_W-1:0] == $past(wr_data)));

   assert_narrow_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && commit_narrow) |-> (commit_data[DATA_W-1:DWORD_W] == '0));

   assert_desc_top_commits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && desc_top) |=> (commit_valid && !commit_narrow &&
                               commit_data[DATA_W-1 -: DWORD_W] == $past(wr_data) &&
                               commit_addr == ($past(wr_addr) & BLK_MASK)));

   assert_desc_low_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_desc && !desc_top) |=> !commit_valid);

   assert_wide_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && !commit_narrow) |-> ((commit_addr & ~BLK_MASK) == '0));
endmodule

bind wide_write_collector ww_collector_chk #(
   .ADDR_W(ADDR_W), .DWORD_W(DWORD_W), .LANES(LANES), .PAGE_LOG2(PAGE_LOG2),
   .WIDE_BASE(WIDE_BASE), .NUM_DESC(NUM_DESC), .DESC_OFS(DESC_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .commit_valid(commit_valid), .commit_narrow(commit_narrow),
   .commit_addr(commit_addr), .commit_data(commit_data)
);

// File: tb/tb_wide_write_collector.sv
`timescale 1ns/1ps
module tb_wide_write_collector;
   localparam int VW = 202;
   localparam int NV = 53;
   // fields: addr16, data32, exp_valid, exp_narrow, exp_addr16, exp_data128, req8
   localparam logic [VW-1:0] VEC [NV] = '{
      // R2: four lanes out of order
      {16'h0800, 32'hA0, 1'b0, 1'b0, 16'h0, 128'h0, 8'd2},
      {16'h0808, 32'hA2, 1'b0, 1'b0, 16'h0, 128'h0, 8'd2},
      {16'h0804, 32'hA1, 1'b0, 1'b0, 16'h0, 128'h0, 8'd2},
      {16'h080C, 32'hA3, 1'b1, 1'b0, 16'h0800, {32'hA3, 32'hA2, 32'hA1, 32'hA0}, 8'd2},
      // R11 then R4: repeated lane
      {16'h080C, 32'hB3, 1'b0, 1'b0, 16'h0, 128'h0, 8'd11},
      {16'h0800, 32'hB0, 1'b0, 1'b0, 16'h0, 128'h0, 8'd4},
      {16'h0804, 32'hB1, 1'b0, 1'b0, 16'h0, 128'h0, 8'd4},
      {16'h0804, 32'hBB1, 1'b0, 1'b0, 16'h0, 128'h0, 8'd4},
      {16'h0808, 32'hB2, 1'b1, 1'b0, 16'h0800, {32'hB3, 32'hB2, 32'hBB1, 32'hB0}, 8'd4},
      // R10: narrow write inside a collection
      {16'h0900, 32'hC0, 1'b0, 1'b0, 16'h0, 128'h0, 8'd10},
      {16'h0100, 32'h111, 1'b1, 1'b1, 16'h0100, {96'h0, 32'h111}, 8'd10},
      {16'h0904, 32'hC1, 1'b0, 1'b0, 16'h0, 128'h0, 8'd10},
      {16'h0908, 32'hC2, 1'b0, 1'b0, 16'h0, 128'h0, 8'd10},
      {16'h090C, 32'hC3, 1'b1, 1'b0, 16'h0900, {32'hC3, 32'hC2, 32'hC1, 32'hC0}, 8'd10},
      // R5: switch register mid-collection
      {16'h0800, 32'hD0, 1'b0, 1'b0, 16'h0, 128'h0, 8'd5},
      {16'h0904, 32'hE1, 1'b0, 1'b0, 16'h0, 128'h0, 8'd5},
      {16'h0900, 32'hE0, 1'b0, 1'b0, 16'h0, 128'h0, 8'd5},
      {16'h0908, 32'hE2, 1'b0, 1'b0, 16'h0, 128'h0, 8'd5},
      {16'h090C, 32'hE3, 1'b1, 1'b0, 16'h0900, {32'hE3, 32'hE2, 32'hE1, 32'hE0}, 8'd5},
      {16'h0804, 32'hD1, 1'b0, 1'b0, 16'h0, 128'h0, 8'd5},
      {16'h0808, 32'hD2, 1'b0, 1'b0, 16'h0, 128'h0, 8'd5},
      {16'h080C, 32'hD3, 1'b0, 1'b0, 16'h0, 128'h0, 8'd5},
      {16'h0800, 32'hDD0, 1'b1, 1'b0, 16'h0800, {32'hD3, 32'hD2, 32'hD1, 32'hDD0}, 8'd5},
      // R6: descriptor top lane, empty then partial collector
      {16'h083C, 32'hF3, 1'b1, 1'b0, 16'h0830, {32'hF3, 96'h0}, 8'd6},
      {16'h0830, 32'h60, 1'b0, 1'b0, 16'h0, 128'h0, 8'd6},
      {16'h0834, 32'h61, 1'b0, 1'b0, 16'h0, 128'h0, 8'd6},
      {16'h083C, 32'h63, 1'b1, 1'b0, 16'h0830, {32'h63, 32'h0, 32'h61, 32'h60}, 8'd6},
      // R7: low descriptor lane dropped, other register kept
      {16'h0800, 32'h70, 1'b0, 1'b0, 16'h0, 128'h0, 8'd7},
      {16'h0A10, 32'h7A0, 1'b0, 1'b0, 16'h0, 128'h0, 8'd7},
      {16'h0804, 32'h71, 1'b0, 1'b0, 16'h0, 128'h0, 8'd7},
      {16'h0808, 32'h72, 1'b0, 1'b0, 16'h0, 128'h0, 8'd7},
      {16'h080C, 32'h73, 1'b1, 1'b0, 16'h0800, {32'h73, 32'h72, 32'h71, 32'h70}, 8'd7},
      {16'h0A1C, 32'h7A3, 1'b1, 1'b0, 16'h0A10, {32'h7A3, 96'h0}, 8'd7},
      // R8: descriptor in page 3
      {16'h6A14, 32'h81, 1'b0, 1'b0, 16'h0, 128'h0, 8'd8},
      {16'h6A1C, 32'h83, 1'b1, 1'b0, 16'h6A10, {32'h83, 32'h0, 32'h81, 32'h0}, 8'd8},
      // R6 + R8: page-1 descriptor top while another register is held
      {16'h0800, 32'h90, 1'b0, 1'b0, 16'h0, 128'h0, 8'd6},
      {16'h283C, 32'h93, 1'b1, 1'b0, 16'h2830, {32'h93, 96'h0}, 8'd6},
      // R11: collector emptied by that commit
      {16'h0804, 32'h91, 1'b0, 1'b0, 16'h0, 128'h0, 8'd11},
      {16'h0808, 32'h92, 1'b0, 1'b0, 16'h0, 128'h0, 8'd11},
      {16'h080C, 32'h3B, 1'b0, 1'b0, 16'h0, 128'h0, 8'd11},
      {16'h0800, 32'h110, 1'b1, 1'b0, 16'h0800, {32'h3B, 32'h92, 32'h91, 32'h110}, 8'd11},
      // R9: page-0 timer clears
      {16'h0800, 32'h50, 1'b0, 1'b0, 16'h0, 128'h0, 8'd9},
      {16'h0420, 32'h5A, 1'b1, 1'b1, 16'h0420, {96'h0, 32'h5A}, 8'd9},
      {16'h0804, 32'h51, 1'b0, 1'b0, 16'h0, 128'h0, 8'd9},
      {16'h0808, 32'h52, 1'b0, 1'b0, 16'h0, 128'h0, 8'd9},
      {16'h080C, 32'h53, 1'b0, 1'b0, 16'h0, 128'h0, 8'd9},
      {16'h0800, 32'h220, 1'b1, 1'b0, 16'h0800, {32'h53, 32'h52, 32'h51, 32'h220}, 8'd9},
      // R9: page-1 timer does not clear
      {16'h0800, 32'h40, 1'b0, 1'b0, 16'h0, 128'h0, 8'd9},
      {16'h2420, 32'h4A, 1'b1, 1'b1, 16'h2420, {96'h0, 32'h4A}, 8'd9},
      {16'h0804, 32'h41, 1'b0, 1'b0, 16'h0, 128'h0, 8'd9},
      {16'h0808, 32'h42, 1'b0, 1'b0, 16'h0, 128'h0, 8'd9},
      {16'h080C, 32'h43, 1'b1, 1'b0, 16'h0800, {32'h43, 32'h42, 32'h41, 32'h40}, 8'd9},
      // R10: byte bits of a narrow address are cleared
      {16'h0102, 32'h222, 1'b1, 1'b1, 16'h0100, {96'h0, 32'h222}, 8'd10}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [15:0]  wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic         commit_valid;
   logic         commit_narrow;
   logic [15:0]  commit_addr;
   logic [127:0] commit_data;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wide_write_collector dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .commit_valid(commit_valid), .commit_narrow(commit_narrow),
      .commit_addr(commit_addr), .commit_data(commit_data)
   );

   task automatic chk(input bit ok, input int req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [15:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic idle();
      wr_en = 1'b0;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(commit_valid == 1'b0, 1, "valid after reset", 128'(commit_valid), 128'h0);
      chk(commit_addr == 16'h0, 1, "addr after reset", 128'(commit_addr), 128'h0);
      chk(commit_data == 128'h0, 1, "data after reset", commit_data, 128'h0);

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         logic          ev, en;
         logic [15:0]   ea;
         logic [127:0]  ed;
         int            rq;
         bit            ok;
         v  = VEC[i];
         ev = v[153]; en = v[152]; ea = v[151:136]; ed = v[135:8]; rq = int'(v[7:0]);
         put(v[201:186], v[185:154]);
         ok = (commit_valid == ev) &&
              (!ev || (commit_narrow == en && commit_addr == ea && commit_data == ed));
         chk(ok, rq, $sformatf("vector %0d valid %b/%b narrow %b/%b addr %h/%h",
             i, commit_valid, ev, commit_narrow, en, commit_addr, ea), commit_data, ed);
      end

      // R3: strobe lasts one cycle, value held afterwards
      idle();
      chk(commit_valid == 1'b0, 3, "strobe after idle", 128'(commit_valid), 128'h0);
      chk(commit_addr == 16'h0100 && commit_data == 128'h222, 3, "held value",
          commit_data, 128'h222);
      idle();
      chk(commit_valid == 1'b0, 3, "no strobe without write", 128'(commit_valid), 128'h0);

      // R1: reset in the middle of a collection
      put(16'h0800, 32'hE00);
      put(16'h0804, 32'hE01);
      wr_en = 1'b0; rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      chk(commit_valid == 1'b0 && commit_data == 128'h0, 1, "mid-collection reset",
          commit_data, 128'h0);
      put(16'h0808, 32'hE02);
      put(16'h080C, 32'hE03);
      chk(commit_valid == 1'b0, 1, "stale lanes after reset", 128'(commit_valid), 128'h0);
      put(16'h0800, 32'hF00);
      put(16'h0804, 32'hF01);
      chk(commit_valid == 1'b1 && commit_data == {32'hE03, 32'hE02, 32'hF01, 32'hF00},
          1, "collection after reset", commit_data, {32'hE03, 32'hE02, 32'hF01, 32'hF00});
      idle();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule